// File: doc/BRIEF.md
# Multi-Bank Selectable Clock Divider

This block sits behind a clock synthesizer. One fast source clock comes in, and it may be either the oscillator output or a reference that has been switched around the loop. The block turns it into three bank clocks and one feedback clock. Each output has its own even divider. The ratio of each divider is decoded from a shared two-bit range select together with a per-output select. Every ratio gives exactly 50% duty, including the ratios that are not a power of two (6, 12, 24, 48).

A single enable input resets the block and marks the pads inactive. While it is low, every divider is cleared and the select inputs are captured. When it goes high, all outputs start from the same phase and their rising edges line up. A separate run input parks the three bank clocks low and leaves the feedback clock running. Parking and unparking take place only at the boundary of an output period, so no shortened pulse is produced.

Top module: `mbank_clkdiv`

## Requirements
- R1: Banks A and B (bank_sel[0], bank_sel[1]) share one ratio table. With range_sel = 2'b00 the ratio is 4 for select 0 and 8 for select 1. With 2'b01 it is 8 or 16. With range_sel[1] = 1 it is 2 or 4.
- R2: Bank C (bank_sel[2]) divides by 8 or 12 for range_sel 2'b00, by 16 or 24 for 2'b01, and by 4 or 6 when range_sel[1] = 1, for select 0 or 1 respectively.
- R3: When range_sel[1] = 1, range_sel[0] has no effect on any ratio.
- R4: The feedback ratio for fb_sel = 0, 1, 2, 3 is 8, 16, 12, 24 at range 2'b00. It is 16, 32, 24, 48 at range 2'b01, and 4, 8, 6, 12 when range_sel[1] = 1.
- R5: Every output is high for exactly half of its period, counted in source cycles.
- R6: While bank_run is low, clk_a, clk_b and clk_c stay low once at most one output period has passed, and clk_fb keeps toggling. When bank_run returns high, the banks resume.
- R7: On a rising source edge with out_en low, all four clocks and out_oe go low and every divider is cleared. On an edge with out_en high, out_oe is high after that edge.
- R8: On the first edge with out_en high after reset, every output that is not parked goes high, so the rising edges of all ratios coincide.
- R9: Parking and unparking take effect only at a period boundary, so every high pulse of a bank clock lasts its full half period.
- R10: Select inputs are captured only while out_en is low. A change made while out_en is high leaves every ratio unchanged until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Fast source clock for all dividers |
| out_en | input | 1 | High: run and drive. Low: synchronous reset, outputs disabled |
| bank_run | input | 1 | Low parks the bank clocks low; the feedback clock is not affected |
| range_sel | input | 2 | Shared range select; bit 1 overrides bit 0 |
| bank_sel | input | 3 | Per-bank ratio select: bit 0 = A, bit 1 = B, bit 2 = C |
| fb_sel | input | 2 | Feedback ratio index |
| clk_a | output | 1 | Bank A clock |
| clk_b | output | 1 | Bank B clock |
| clk_c | output | 1 | Bank C clock |
| clk_fb | output | 1 | Feedback clock |
| out_oe | output | 1 | Pad drive enable; low means the pads float |

## Verification
Every output is a register clocked by clk_src. A change of out_en therefore shows at the outputs one source edge later, and the first high level after release is seen in the cycle right after the first enabled edge. The bench drives inputs on the falling edge and samples on the following falling edges. It measures the first-rise index, the period and the high time for each output over a window longer than two of the longest periods. A bank can take up to one full period of its own ratio to respond to bank_run, so the clock-stop checks look at levels only after a settle margin of more than the largest ratio. The pulse-length check for R9 covers the whole transition.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

  localparam int unsigned NUM_BANKS = 3;

  typedef enum logic [0:0] {
    TBL_AB = 1'b0,
    TBL_C  = 1'b1
  } bank_tbl_e;

  // Ratio at range 00, then halved (high range bit) or doubled (low bit).
  function automatic int unsigned bank_ratio(bank_tbl_e tbl, logic [1:0] rng, logic sel);
    int unsigned base;
    if (tbl == TBL_C) base = sel ? 12 : 8;
    else              base = sel ? 8 : 4;
    if (rng[1])      return base / 2;
    else if (rng[0]) return base * 2;
    else             return base;
  endfunction

  function automatic int unsigned fb_ratio(logic [1:0] rng, logic [1:0] fsel);
    int unsigned base;
    base = (fsel[1] ? 12 : 8) * (fsel[0] ? 2 : 1);
    if (rng[1])      return base / 2;
    else if (rng[0]) return base * 2;
    else             return base;
  endfunction

endpackage

// File: rtl/cdiv_cfg_latch.sv
module cdiv_cfg_latch
  import cdiv_pkg::*;
#(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned NB    = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [1:0]               rng,
  input  logic [NB-1:0]            bank_sel,
  input  logic [1:0]               fb_sel,
  output logic [NB:0][CNT_W-1:0]   ratio_q
);

  // Index NB is the feedback divider; the last bank uses the wide table.
  for (genvar i = 0; i <= NB; i++) begin : g_ratio
    logic [CNT_W-1:0] dec;
    if (i == NB) begin : g_fb
      assign dec = CNT_W'(fb_ratio(rng, fb_sel));
    end else begin : g_bank
      localparam bank_tbl_e TBL = (i == NB - 1) ? TBL_C : TBL_AB;
      assign dec = CNT_W'(bank_ratio(TBL, rng, bank_sel[i]));
    end

    always_ff @(posedge clk) begin
      if (rst) ratio_q[i] <= dec;
    end
  end

endmodule

// File: rtl/cdiv_phase_ctr.sv
module cdiv_phase_ctr #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] ratio,
  output logic             phase_hi,
  output logic             period_start
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half;
  logic [CNT_W-1:0] last;

  assign half = ratio >> 1;
  assign last = ratio - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (cnt_q >= last) cnt_q <= '0;
    else                    cnt_q <= cnt_q + CNT_W'(1);
  end

  assign phase_hi     = (cnt_q < half);
  assign period_start = (cnt_q == '0);

endmodule

// File: rtl/cdiv_out_gate.sv
module cdiv_out_gate #(
  parameter bit STOPPABLE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic phase_hi,
  input  logic period_start,
  input  logic stop_req,
  output logic q
);

  logic park_q;
  logic park_now;

  if (STOPPABLE) begin : g_stop
    // The park decision is renewed only where a new period begins.
    assign park_now = period_start ? stop_req : park_q;
  end else begin : g_free
    assign park_now = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q      <= 1'b0;
      park_q <= 1'b0;
    end else begin
      q      <= phase_hi & ~park_now;
      park_q <= park_now;
    end
  end

endmodule

// File: rtl/mbank_clkdiv.sv
module mbank_clkdiv
  import cdiv_pkg::*;
#(
  parameter int unsigned MAX_RATIO = 48
) (
  input  logic       clk_src,
  input  logic       out_en,
  input  logic       bank_run,
  input  logic [1:0] range_sel,
  input  logic [2:0] bank_sel,
  input  logic [1:0] fb_sel,
  output logic       clk_a,
  output logic       clk_b,
  output logic       clk_c,
  output logic       clk_fb,
  output logic       out_oe
);

  localparam int unsigned CNT_W = $clog2(MAX_RATIO + 1);
  localparam int unsigned NB    = NUM_BANKS;

  logic                   rst;
  logic [NB:0][CNT_W-1:0] ratio_q;
  logic [NB:0]            out_q;

  assign rst = ~out_en;

  cdiv_cfg_latch #(.CNT_W(CNT_W), .NB(NB)) u_cfg (
    .clk      (clk_src),
    .rst      (rst),
    .rng      (range_sel),
    .bank_sel (bank_sel),
    .fb_sel   (fb_sel),
    .ratio_q  (ratio_q)
  );

  for (genvar i = 0; i <= NB; i++) begin : g_out
    logic phase_hi;
    logic period_start;

    cdiv_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk          (clk_src),
      .rst          (rst),
      .ratio        (ratio_q[i]),
      .phase_hi     (phase_hi),
      .period_start (period_start)
    );

    cdiv_out_gate #(.STOPPABLE(i != NB)) u_gate (
      .clk          (clk_src),
      .rst          (rst),
      .phase_hi     (phase_hi),
      .period_start (period_start),
      .stop_req     (~bank_run),
      .q            (out_q[i])
    );
  end

  always_ff @(posedge clk_src) begin
    if (rst) out_oe <= 1'b0;
    else     out_oe <= 1'b1;
  end

  assign clk_a  = out_q[0];
  assign clk_b  = out_q[1];
  assign clk_c  = out_q[2];
  assign clk_fb = out_q[NB];

endmodule

// File: rtl/cdiv_checker.sv
module cdiv_checker #(
  parameter int unsigned MAX_RATIO = 48
) (
  input logic clk_src,
  input logic out_en,
  input logic bank_run,
  input logic clk_a,
  input logic clk_b,
  input logic clk_c,
  input logic clk_fb,
  input logic out_oe
);

  localparam int unsigned LIMIT = MAX_RATIO + 2;
  localparam int unsigned SC_W  = $clog2(LIMIT + 1);

  logic            seen_rst = 1'b0;
  logic [SC_W-1:0] stop_cnt = '0;

  always_ff @(posedge clk_src) begin
    if (!out_en) seen_rst <= 1'b1;
    if (!out_en || bank_run)          stop_cnt <= '0;
    else if (stop_cnt < SC_W'(LIMIT)) stop_cnt <= stop_cnt + SC_W'(1);
  end

  p_off_r7: assert property (@(posedge clk_src) disable iff (!seen_rst)
    !out_en |=> (!out_oe && !clk_a && !clk_b && !clk_c && !clk_fb));

  p_on_r7: assert property (@(posedge clk_src) disable iff (!seen_rst)
    out_en |=> out_oe);

  p_float_low_r7: assert property (@(posedge clk_src) disable iff (!seen_rst)
    !out_oe |-> !(clk_a || clk_b || clk_c || clk_fb));

  p_bank_phase_r8: assert property (@(posedge clk_src) disable iff (!seen_rst)
    ($rose(out_en) && bank_run) |=> (clk_a && clk_b && clk_c));

  p_fb_phase_r8: assert property (@(posedge clk_src) disable iff (!seen_rst)
    $rose(out_en) |=> clk_fb);

  p_park_low_r6: assert property (@(posedge clk_src) disable iff (!seen_rst)
    (stop_cnt >= SC_W'(LIMIT)) |-> (!clk_a && !clk_b && !clk_c));

endmodule

bind mbank_clkdiv cdiv_checker #(.MAX_RATIO(MAX_RATIO)) u_chk (.*);

// File: tb/mbank_clkdiv_bench.sv
module mbank_clkdiv_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk_src = 1'b0;
  logic       out_en = 1'b0;
  logic       bank_run = 1'b1;
  logic [1:0] range_sel = '0;
  logic [2:0] bank_sel = '0;
  logic [1:0] fb_sel = '0;
  logic       clk_a, clk_b, clk_c, clk_fb, out_oe;

  int checks = 0;
  int fails  = 0;
  int m_first[4];
  int m_per[4];
  int m_hi[4];
  int expv[4];

  always #(CLK_PERIOD / 2) clk_src = ~clk_src;

  mbank_clkdiv u_mbank_clkdiv (
    .clk_src (clk_src), .out_en (out_en), .bank_run (bank_run),
    .range_sel (range_sel), .bank_sel (bank_sel), .fb_sel (fb_sel),
    .clk_a (clk_a), .clk_b (clk_b), .clk_c (clk_c), .clk_fb (clk_fb),
    .out_oe (out_oe)
  );

  function automatic int exp_ab(logic [1:0] r, logic s);
    if (r[1])      return s ? 4 : 2;
    else if (r[0]) return s ? 16 : 8;
    else           return s ? 8 : 4;
  endfunction

  function automatic int exp_c(logic [1:0] r, logic s);
    if (r[1])      return s ? 6 : 4;
    else if (r[0]) return s ? 24 : 16;
    else           return s ? 12 : 8;
  endfunction

  function automatic int exp_fb(logic [1:0] r, logic [1:0] f);
    if (r[1]) begin
      case (f) 2'd0: return 4; 2'd1: return 8; 2'd2: return 6; default: return 12; endcase
    end else if (r[0]) begin
      case (f) 2'd0: return 16; 2'd1: return 32; 2'd2: return 24; default: return 48; endcase
    end else begin
      case (f) 2'd0: return 8; 2'd1: return 16; 2'd2: return 12; default: return 24; endcase
    end
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic apply_cfg(logic [1:0] r, logic [2:0] s, logic [1:0] f);
    @(negedge clk_src);
    out_en = 1'b0; range_sel = r; bank_sel = s; fb_sel = f;
    repeat (2) @(negedge clk_src);
    out_en = 1'b1;
    expv[0] = exp_ab(r, s[0]);
    expv[1] = exp_ab(r, s[1]);
    expv[2] = exp_c(r, s[2]);
    expv[3] = exp_fb(r, f);
  endtask

  task automatic measure(int len);
    logic [3:0] prev, cur;
    int rc[4];
    prev = {clk_fb, clk_c, clk_b, clk_a};
    for (int k = 0; k < 4; k++) begin
      rc[k] = 0; m_first[k] = -1; m_per[k] = 0; m_hi[k] = 0;
    end
    for (int n = 1; n <= len; n++) begin
      @(negedge clk_src);
      cur = {clk_fb, clk_c, clk_b, clk_a};
      for (int k = 0; k < 4; k++) begin
        if (cur[k] && !prev[k]) begin
          if (rc[k] == 0)      m_first[k] = n;
          else if (rc[k] == 1) m_per[k] = n - m_first[k];
          rc[k]++;
        end
        if (cur[k] && rc[k] == 1) m_hi[k]++;
      end
      prev = cur;
    end
  endtask

  task automatic run_and_check(logic [1:0] r, logic [2:0] s, logic [1:0] f);
    string tag;
    apply_cfg(r, s, f);
    measure(110);
    for (int k = 0; k < 4; k++) begin
      tag = (k < 2) ? "R1" : (k == 2) ? "R2" : "R4";
      if (r[1]) tag = "R3";
      chk(m_per[k] == expv[k], tag, $sformatf("period out%0d r=%0d", k, r), m_per[k], expv[k]);
      chk(m_hi[k] == expv[k] / 2, "R5", $sformatf("high time out%0d", k), m_hi[k], expv[k] / 2);
      chk(m_first[k] == 1, "R8", $sformatf("first rise out%0d", k), m_first[k], 1);
    end
    chk(out_oe == 1'b1, "R7", "out_oe while enabled", int'(out_oe), 1);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk_src);
    fails++;
    $display("FAIL R7 watchdog: actual %0d cycles expected fewer", WATCHDOG);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    int stop_at;
    int run_a, bad_run, low_bad, fb_rises, a_after;
    logic pa, pf;
    seed = $urandom(20240611);

    // Reset state, R7
    repeat (3) @(negedge clk_src);
    chk({clk_a, clk_b, clk_c, clk_fb, out_oe} == 5'b0, "R7", "reset outputs",
        int'({clk_a, clk_b, clk_c, clk_fb, out_oe}), 0);

    // Directed sweep of range and feedback index, random bank selects
    for (int r = 0; r < 4; r++)
      for (int f = 0; f < 4; f++)
        run_and_check(2'(r), 3'($urandom % 8), 2'(f));

    // Directed corners: all selects high / low at both high-range codes (R3)
    run_and_check(2'b10, 3'b111, 2'b11);
    run_and_check(2'b11, 3'b111, 2'b11);
    run_and_check(2'b01, 3'b000, 2'b00);

    // Random configurations
    for (int i = 0; i < 12; i++)
      run_and_check(2'($urandom % 4), 3'($urandom % 8), 2'($urandom % 4));

    // R10: select change while enabled is ignored
    apply_cfg(2'b00, 3'b000, 2'b00);
    @(negedge clk_src);
    range_sel = 2'b01; bank_sel = 3'b111; fb_sel = 2'b11;
    measure(120);
    chk(m_per[0] == 4, "R10", "bank A ratio held", m_per[0], 4);
    chk(m_per[2] == 8, "R10", "bank C ratio held", m_per[2], 8);
    chk(m_per[3] == 8, "R10", "feedback ratio held", m_per[3], 8);
    run_and_check(2'b01, 3'b111, 2'b11);

    // R6 / R9: clock stop with a random entry point
    apply_cfg(2'b00, 3'b111, 2'b00);
    stop_at = 100 + int'($urandom % 9);
    run_a = 0; bad_run = 0; low_bad = 0; fb_rises = 0; a_after = 0;
    pa = 1'b0; pf = 1'b0;
    for (int n = 1; n <= 400; n++) begin
      @(negedge clk_src);
      if (clk_a) run_a++;
      else if (pa) begin
        if (run_a != 4) bad_run++;
        run_a = 0;
      end
      if (n > stop_at + 20 && n < 250) begin
        if (clk_a || clk_b || clk_c) low_bad++;
        if (clk_fb && !pf) fb_rises++;
      end
      if (n > 260 && clk_a && !pa) a_after++;
      pa = clk_a; pf = clk_fb;
      if (n == stop_at) bank_run = 1'b0;
      if (n == 250)     bank_run = 1'b1;
    end
    chk(bad_run == 0, "R9", "short bank A pulses", bad_run, 0);
    chk(low_bad == 0, "R6", "bank high while parked", low_bad, 0);
    chk(fb_rises >= 10, "R6", "feedback rises while parked", fb_rises, 10);
    chk(a_after >= 10, "R6", "bank A rises after unpark", a_after, 10);

    // R7: disable while running
    @(negedge clk_src);
    out_en = 1'b0;
    @(negedge clk_src);
    chk({clk_a, clk_b, clk_c, clk_fb, out_oe} == 5'b0, "R7", "outputs after disable",
        int'({clk_a, clk_b, clk_c, clk_fb, out_oe}), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule